// File: doc/BRIEF.md
# Dual-mode hash/keystream sequencer

This block is the control unit for a sponge-like round engine that is shared by two protocols. A one-way hash absorbs a padded message, and a stream cipher is seeded with a key and a diversification value. In every cycle the sequencer tells the datapath which iteration to perform: hold, clear, push or pull. It chooses which 256-bit source feeds a push. It also decides whether the datapath's pull result is released to the consumer. Padding and the round transform live outside this block.

Both protocols begin by clearing the engine. In hash mode the sequencer then pushes one message block for each cycle in which a block is offered, and the block flagged as the last one ends the absorb phase. In stream mode it pushes the key and then the diversification value. Both modes then run a fixed series of blank pulls whose results are withheld. Hash mode then releases a single pull as the digest and returns to idle. Stream mode releases one keystream word for each pull, and it pulls only when the consumer is ready. A new request made while keystream is being produced restarts the sequence from the clear step, which is how the cipher is resynchronised with a fresh diversification value.

The released word passes through a registered AND gate, so the data output reads as zero whenever the valid flag is low.

Top module: `dualmode_round_sequencer`

## Requirements
- R1: While `rst` is high, and afterwards until a request arrives, `iter_mode` is hold (2'b00), `msg_ready` is low, `push_word` is zero, `out_valid` is low and `out_data` is zero.
- R2: A request sampled in idle makes `iter_mode` clear (2'b01) for exactly one cycle, starting in the next cycle. If `hash_req` and `crypto_req` are high together, the hash protocol is chosen.
- R3: During hash absorb `msg_ready` is high. A cycle with `msg_valid` high is a push (2'b10) with `in_sel` = message (2'b01) and `push_word` = `msg_data`, and a cycle with `msg_valid` low is a hold. The block flagged by `msg_last` is the final push.
- R4: After the final message push, or after the diversification push, exactly BLANK_PULLS (32) consecutive pull cycles (2'b11) follow, and none of them raises `out_valid`.
- R5: In hash mode the pull that follows the blank run is released. In the next cycle `out_valid` is high for exactly one cycle and `out_data` equals the `dp_result` seen during that pull. The block then returns to idle.
- R6: In stream mode the clear cycle is followed by one push with `in_sel` = key (2'b10) carrying `key_in`, and then one push with `in_sel` = diversification (2'b11) carrying `div_in`.
- R7: After the blank run in stream mode, a cycle with `ks_ready` high is a released pull, and in the next cycle `out_valid` is high with `out_data` equal to that cycle's `dp_result`. A cycle with `ks_ready` low is a hold, and `out_valid` is low in the next cycle.
- R8: `out_data` is zero whenever `out_valid` is low, and `push_word` is zero whenever `iter_mode` is not push.
- R9: A request made during keystream output issues no pull in that cycle. The next cycle is a clear, and the sequence reloads as the request selects (hash has priority).
- R10: Requests made during clear, absorb, key or diversification load, blank run or digest are ignored, and the sequence continues unchanged.
- R11: Message inputs are ignored outside hash absorb: `msg_ready` stays low, and `push_word` never carries `msg_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hash_req | input | 1 | Start (or restart) a hash run |
| crypto_req | input | 1 | Start (or resynchronise) a keystream run |
| key_in | input | 256 | Cipher key, pushed first in stream mode |
| div_in | input | 256 | Diversification value, pushed second in stream mode |
| msg_data | input | 256 | Padded message block |
| msg_valid | input | 1 | Message block offered this cycle |
| msg_last | input | 1 | Offered block is the final one |
| ks_ready | input | 1 | Consumer accepts a keystream word |
| dp_result | input | 256 | Pull output of the datapath in the current cycle |
| iter_mode | output | 2 | 00 hold, 01 clear, 10 push, 11 pull |
| in_sel | output | 2 | Push source: 00 none, 01 message, 10 key, 11 diversification |
| push_word | output | 256 | Selected push input, zero when not pushing |
| msg_ready | output | 1 | Hash absorb phase is open |
| out_valid | output | 1 | Released digest or keystream word present |
| out_data | output | 256 | Released word, zero when not valid |

## Verification
The bench builds the block with its default parameters: 32-bit words, eight lanes and a blank run of 32 pulls. The run length seen at the ports is therefore the real one, and a counter that stops one pull early or one pull late shows up at the boundary between the blank run and the release. Each lane carries distinct data both in the message and in the datapath result, so a swapped lane or a wrong source slice in the push multiplexer or the output gate cannot pass unnoticed. Irregular valid and ready patterns bring the hold cycles within the absorb and keystream phases into reach.

// File: rtl/seqr_pkg.sv
package seqr_pkg;

  typedef enum logic [1:0] {
    IT_HOLD  = 2'b00,
    IT_CLEAR = 2'b01,
    IT_PUSH  = 2'b10,
    IT_PULL  = 2'b11
  } iter_e;

  typedef enum logic [1:0] {
    SRC_NONE = 2'b00,
    SRC_MSG  = 2'b01,
    SRC_KEY  = 2'b10,
    SRC_DIV  = 2'b11
  } src_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CLEAR,
    PH_ABSORB,
    PH_KEY,
    PH_DIV,
    PH_BLANK,
    PH_DIGEST,
    PH_STREAM
  } phase_e;

endpackage

// File: rtl/seqr_blank_counter.sv
module seqr_blank_counter #(
  parameter int RUN_LEN = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic at_last
);
  localparam int CW = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);

  logic [CW-1:0] count_q;

  // Held at zero outside the blank run, so every run starts from zero.
  always_ff @(posedge clk) begin
    if (rst || !run)         count_q <= '0;
    else if (count_q != LAST) count_q <= count_q + 1'b1;
  end

  assign at_last = (count_q == LAST);

  assert_cnt_range_R4: assert property (@(posedge clk) disable iff (rst)
    count_q <= LAST);

  assert_cnt_step_R4: assert property (@(posedge clk) disable iff (rst)
    (run && !at_last) |=> (count_q == $past(count_q) + 1'b1));

  assert_cnt_idle_R4: assert property (@(posedge clk) disable iff (rst)
    !run |=> (count_q == '0));

endmodule

// File: rtl/seqr_ctrl_fsm.sv
module seqr_ctrl_fsm
  import seqr_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   hash_req,
  input  logic   crypto_req,
  input  logic   msg_valid,
  input  logic   msg_last,
  input  logic   ks_ready,
  input  logic   blank_done,
  output phase_e phase,
  output iter_e  mode,
  output src_e   src,
  output logic   take_result,
  output logic   hash_op,
  output logic   absorb_open,
  output logic   blank_run
);
  phase_e phase_nxt;
  logic   op_nxt;
  logic   any_req;

  assign any_req = hash_req | crypto_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      hash_op <= 1'b0;
    end else begin
      phase   <= phase_nxt;
      hash_op <= op_nxt;
    end
  end

  always_comb begin
    phase_nxt = phase;
    op_nxt    = hash_op;
    case (phase)
      PH_IDLE, PH_STREAM: begin
        if (hash_req) begin
          phase_nxt = PH_CLEAR;
          op_nxt    = 1'b1;
        end else if (crypto_req) begin
          phase_nxt = PH_CLEAR;
          op_nxt    = 1'b0;
        end
      end
      PH_CLEAR:  phase_nxt = hash_op ? PH_ABSORB : PH_KEY;
      PH_ABSORB: if (msg_valid && msg_last) phase_nxt = PH_BLANK;
      PH_KEY:    phase_nxt = PH_DIV;
      PH_DIV:    phase_nxt = PH_BLANK;
      PH_BLANK:  if (blank_done) phase_nxt = hash_op ? PH_DIGEST : PH_STREAM;
      PH_DIGEST: phase_nxt = PH_IDLE;
      default:   phase_nxt = PH_IDLE;
    endcase
  end

  always_comb begin
    mode        = IT_HOLD;
    src         = SRC_NONE;
    take_result = 1'b0;
    case (phase)
      PH_CLEAR:  mode = IT_CLEAR;
      PH_ABSORB: if (msg_valid) begin
        mode = IT_PUSH;
        src  = SRC_MSG;
      end
      PH_KEY: begin
        mode = IT_PUSH;
        src  = SRC_KEY;
      end
      PH_DIV: begin
        mode = IT_PUSH;
        src  = SRC_DIV;
      end
      PH_BLANK:  mode = IT_PULL;
      PH_DIGEST: begin
        mode        = IT_PULL;
        take_result = 1'b1;
      end
      PH_STREAM: if (ks_ready && !any_req) begin
        mode        = IT_PULL;
        take_result = 1'b1;
      end
      default: mode = IT_HOLD;
    endcase
  end

  assign absorb_open = (phase == PH_ABSORB);
  assign blank_run   = (phase == PH_BLANK);

  assert_one_clear_R2: assert property (@(posedge clk) disable iff (rst)
    (mode == IT_CLEAR) |=> (mode != IT_CLEAR));

  assert_last_to_blank_R3: assert property (@(posedge clk) disable iff (rst)
    (absorb_open && msg_valid && msg_last) |=> (mode == IT_PULL && !take_result));

  assert_key_then_div_R6: assert property (@(posedge clk) disable iff (rst)
    (mode == IT_PUSH && src == SRC_KEY) |=> (mode == IT_PUSH && src == SRC_DIV));

  assert_restart_R9: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_STREAM && any_req) |=> (mode == IT_CLEAR));

  assert_blank_busy_R10: assert property (@(posedge clk) disable iff (rst)
    blank_run |=> (phase == PH_BLANK || phase == PH_DIGEST || phase == PH_STREAM));

endmodule

// File: rtl/seqr_push_mux.sv
module seqr_push_mux
  import seqr_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int LANES  = 8
) (
  input  src_e                      sel,
  input  logic [WORD_W*LANES-1:0]   msg_word,
  input  logic [WORD_W*LANES-1:0]   key_word,
  input  logic [WORD_W*LANES-1:0]   div_word,
  output logic [WORD_W*LANES-1:0]   push_word
);
  logic [WORD_W-1:0] lane_w [LANES];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_comb begin
      case (sel)
        SRC_MSG: lane_w[l] = msg_word[l*WORD_W +: WORD_W];
        SRC_KEY: lane_w[l] = key_word[l*WORD_W +: WORD_W];
        SRC_DIV: lane_w[l] = div_word[l*WORD_W +: WORD_W];
        default: lane_w[l] = '0;
      endcase
    end
    assign push_word[l*WORD_W +: WORD_W] = lane_w[l];
  end

endmodule

// File: rtl/seqr_out_gate.sv
module seqr_out_gate #(
  parameter int WORD_W = 32,
  parameter int LANES  = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    take,
  input  logic [WORD_W*LANES-1:0] result,
  output logic                    out_valid,
  output logic [WORD_W*LANES-1:0] out_data
);
  logic [WORD_W-1:0] lane_q [LANES];

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= take;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) lane_q[l] <= '0;
      else     lane_q[l] <= result[l*WORD_W +: WORD_W] & {WORD_W{take}};
    end
    assign out_data[l*WORD_W +: WORD_W] = lane_q[l];
  end

endmodule

// File: rtl/dualmode_round_sequencer.sv
module dualmode_round_sequencer
  import seqr_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int LANES       = 8,
  parameter int BLANK_PULLS = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    hash_req,
  input  logic                    crypto_req,
  input  logic [WORD_W*LANES-1:0] key_in,
  input  logic [WORD_W*LANES-1:0] div_in,
  input  logic [WORD_W*LANES-1:0] msg_data,
  input  logic                    msg_valid,
  input  logic                    msg_last,
  input  logic                    ks_ready,
  input  logic [WORD_W*LANES-1:0] dp_result,
  output logic [1:0]              iter_mode,
  output logic [1:0]              in_sel,
  output logic [WORD_W*LANES-1:0] push_word,
  output logic                    msg_ready,
  output logic                    out_valid,
  output logic [WORD_W*LANES-1:0] out_data
);
  localparam int BLK_W = WORD_W * LANES;

  phase_e phase;
  iter_e  mode;
  src_e   src;
  logic   take_result;
  logic   hash_op;
  logic   blank_run;
  logic   blank_done;

  seqr_blank_counter #(.RUN_LEN(BLANK_PULLS)) u_blank (
    .clk     (clk),
    .rst     (rst),
    .run     (blank_run),
    .at_last (blank_done)
  );

  seqr_ctrl_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .hash_req    (hash_req),
    .crypto_req  (crypto_req),
    .msg_valid   (msg_valid),
    .msg_last    (msg_last),
    .ks_ready    (ks_ready),
    .blank_done  (blank_done),
    .phase       (phase),
    .mode        (mode),
    .src         (src),
    .take_result (take_result),
    .hash_op     (hash_op),
    .absorb_open (msg_ready),
    .blank_run   (blank_run)
  );

  seqr_push_mux #(.WORD_W(WORD_W), .LANES(LANES)) u_mux (
    .sel       (src),
    .msg_word  (msg_data),
    .key_word  (key_in),
    .div_word  (div_in),
    .push_word (push_word)
  );

  seqr_out_gate #(.WORD_W(WORD_W), .LANES(LANES)) u_gate (
    .clk       (clk),
    .rst       (rst),
    .take      (take_result),
    .result    (dp_result),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  assign iter_mode = mode;
  assign in_sel    = src;

  assert_start_clear_R2: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IDLE && (hash_req || crypto_req)) |=> (iter_mode == IT_CLEAR));

  assert_blank_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    (iter_mode == IT_PULL && !take_result) |=> !out_valid);

  assert_digest_single_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && hash_op) |=> !out_valid);

  assert_ks_ready_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !hash_op) |-> $past(ks_ready));

  assert_zero_gate_R8: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (out_data == {BLK_W{1'b0}}));

  assert_push_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (iter_mode != IT_PUSH) |-> (push_word == {BLK_W{1'b0}}));

  assert_msg_closed_R11: assert property (@(posedge clk) disable iff (rst)
    !msg_ready |-> (in_sel != SRC_MSG));

endmodule

// File: tb/dualmode_round_sequencer_tb_top.sv
module dualmode_round_sequencer_tb_top;
  localparam int BL = 32;
  localparam logic [1:0] M_HOLD = 2'b00, M_CLR = 2'b01, M_PUSH = 2'b10, M_PULL = 2'b11;
  localparam logic [1:0] S_NONE = 2'b00, S_MSG = 2'b01, S_KEY = 2'b10, S_DIV = 2'b11;

  // Vector: {stream flag, count (blocks or keystream words), valid/ready pattern}
  localparam logic [12:0] VECS [0:5] = '{
    {1'b0, 4'd1,  8'hFF},
    {1'b0, 4'd4,  8'hA5},
    {1'b0, 4'd11, 8'h81},
    {1'b1, 4'd3,  8'hFF},
    {1'b1, 4'd6,  8'h6C},
    {1'b1, 4'd2,  8'h01}
  };

  logic         clk = 1'b0;
  logic         rst, hash_req, crypto_req, msg_valid, msg_last, ks_ready;
  logic [255:0] key_in, div_in, msg_data, dp_result, push_word, out_data;
  logic [1:0]   iter_mode, in_sel;
  logic         msg_ready, out_valid;
  logic [31:0]  cyc = 32'd0;
  int           n_chk = 0;
  int           n_fail = 0;
  bit           done = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign dp_result = {cyc ^ 32'h11, cyc ^ 32'h22, cyc ^ 32'h33, cyc ^ 32'h44,
                      cyc ^ 32'h55, cyc ^ 32'h66, cyc ^ 32'h77, cyc ^ 32'h88};

  dualmode_round_sequencer dut_i (
    .clk(clk), .rst(rst), .hash_req(hash_req), .crypto_req(crypto_req),
    .key_in(key_in), .div_in(div_in), .msg_data(msg_data), .msg_valid(msg_valid),
    .msg_last(msg_last), .ks_ready(ks_ready), .dp_result(dp_result),
    .iter_mode(iter_mode), .in_sel(in_sel), .push_word(push_word),
    .msg_ready(msg_ready), .out_valid(out_valid), .out_data(out_data)
  );

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic adv();
    @(posedge clk);
    #2;
  endtask

  function automatic logic [255:0] mkblk(input int b);
    logic [255:0] w;
    for (int l = 0; l < 8; l++) w[l*32 +: 32] = 32'hB10C_0000 + 32'(b * 16 + l);
    return w;
  endfunction

  task automatic do_reset();
    rst = 1'b1; hash_req = 1'b0; crypto_req = 1'b0; msg_valid = 1'b0; msg_last = 1'b0;
    ks_ready = 1'b0; key_in = '0; div_in = '0; msg_data = '0;
    adv();
    msg_valid = 1'b1; msg_data = mkblk(99);
    #1;
    chk("R1 mode in reset", iter_mode, M_HOLD);
    chk("R1 valid in reset", out_valid, 1'b0);
    adv();
    rst = 1'b0; msg_valid = 1'b0; msg_data = '0;
  endtask

  task automatic blank_run(input string who);
    for (int k = 0; k < BL; k++) begin
      hash_req = (k < BL - 2); msg_valid = 1'b1; msg_data = mkblk(77); ks_ready = 1'b1;
      #1;
      chk({"R4 blank pull ", who}, iter_mode, M_PULL);
      chk({"R4 blank quiet ", who}, out_valid, 1'b0);
      chk("R8 blank data zero", out_data, '0);
      chk("R11 blank push zero", push_word, '0);
      chk("R11 blank msg_ready", msg_ready, 1'b0);
      adv();
    end
    hash_req = 1'b0; msg_valid = 1'b0; ks_ready = 1'b0;
  endtask

  task automatic run_hash(input int nblk, input logic [7:0] mask);
    logic [255:0] exp;
    int b = 0;
    int i = 0;
    hash_req = 1'b1;
    #1;
    chk("R1 idle mode", iter_mode, M_HOLD);
    adv();
    hash_req = 1'b0;
    #1;
    chk("R2 clear", iter_mode, M_CLR);
    adv();
    while (b < nblk) begin
      crypto_req = 1'b1;
      if (mask[i % 8]) begin
        msg_valid = 1'b1; msg_data = mkblk(b); msg_last = (b == nblk - 1);
        #1;
        chk("R3 push", iter_mode, M_PUSH);
        chk("R3 sel", in_sel, S_MSG);
        chk("R3 word", push_word, mkblk(b));
        b++;
      end else begin
        msg_valid = 1'b0; msg_last = 1'b0;
        #1;
        chk("R3 gap hold", iter_mode, M_HOLD);
        chk("R10 absorb kept", msg_ready, 1'b1);
      end
      i++;
      adv();
    end
    crypto_req = 1'b0; msg_last = 1'b0;
    blank_run("hash");
    #1;
    chk("R5 digest pull", iter_mode, M_PULL);
    chk("R4 no early release", out_valid, 1'b0);
    exp = dp_result;
    adv();
    #1;
    chk("R5 digest valid", out_valid, 1'b1);
    chk("R5 digest data", out_data, exp);
    chk("R5 back to idle", iter_mode, M_HOLD);
    adv();
    #1;
    chk("R5 single digest", out_valid, 1'b0);
    chk("R8 data cleared", out_data, '0);
  endtask

  task automatic run_stream(input int nw, input logic [7:0] mask,
                            input logic [255:0] k, input logic [255:0] d);
    logic [255:0] prev_d = '0;
    logic prev_p = 1'b0;
    int got = 0;
    int i = 0;
    crypto_req = 1'b1; key_in = k; div_in = d;
    #1;
    adv();
    crypto_req = 1'b0;
    #1;
    chk("R2 clear stream", iter_mode, M_CLR);
    adv();
    #1;
    chk("R6 key push", iter_mode, M_PUSH);
    chk("R6 key sel", in_sel, S_KEY);
    chk("R6 key word", push_word, k);
    adv();
    #1;
    chk("R6 div push", iter_mode, M_PUSH);
    chk("R6 div sel", in_sel, S_DIV);
    chk("R6 div word", push_word, d);
    adv();
    blank_run("stream");
    while (got < nw) begin
      ks_ready = mask[i % 8];
      #1;
      chk("R7 valid follows ready", out_valid, prev_p);
      if (prev_p) chk("R7 keystream data", out_data, prev_d);
      if (ks_ready) begin
        chk("R7 ready pull", iter_mode, M_PULL);
        prev_d = dp_result;
        got++;
      end else begin
        chk("R7 stall hold", iter_mode, M_HOLD);
      end
      prev_p = ks_ready;
      i++;
      adv();
    end
    ks_ready = 1'b0;
    #1;
    chk("R7 last valid", out_valid, prev_p);
    chk("R7 last data", out_data, prev_d);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    do_reset();
    #1;
    chk("R1 mode after reset", iter_mode, M_HOLD);
    chk("R1 msg_ready after reset", msg_ready, 1'b0);
    chk("R1 push zero", push_word, '0);
    chk("R1 valid low", out_valid, 1'b0);
    chk("R1 data zero", out_data, '0);

    for (int v = 0; v < 6; v++) begin
      do_reset();
      if (VECS[v][12])
        run_stream(int'(VECS[v][11:8]), VECS[v][7:0],
                   {8{32'hC0DE_0000 + 32'(v)}}, {4{32'hD1F0_0000 + 32'(v), 32'h0F0F_1234}});
      else
        run_hash(int'(VECS[v][11:8]), VECS[v][7:0]);
    end

    // R11: message inputs in idle
    do_reset();
    msg_valid = 1'b1; msg_last = 1'b1; msg_data = mkblk(5); ks_ready = 1'b1;
    #1;
    chk("R11 idle hold", iter_mode, M_HOLD);
    chk("R11 idle push zero", push_word, '0);
    chk("R11 idle msg_ready", msg_ready, 1'b0);
    adv();
    #1;
    chk("R11 still idle", iter_mode, M_HOLD);
    chk("R11 no output", out_valid, 1'b0);
    msg_valid = 1'b0; msg_last = 1'b0; ks_ready = 1'b0;

    // R2: both requests at once pick hash; R10: request during absorb ignored
    do_reset();
    hash_req = 1'b1; crypto_req = 1'b1;
    #1;
    adv();
    hash_req = 1'b0; crypto_req = 1'b0;
    #1;
    chk("R2 clear on both", iter_mode, M_CLR);
    adv();
    #1;
    chk("R2 hash priority", msg_ready, 1'b1);
    crypto_req = 1'b1;
    adv();
    crypto_req = 1'b0;
    #1;
    chk("R10 absorb not restarted", iter_mode, M_HOLD);
    chk("R10 absorb still open", msg_ready, 1'b1);

    // R9: resync with fresh diversification value
    do_reset();
    run_stream(2, 8'hFF, {8{32'hAAAA_5555}}, {8{32'h0000_0001}});
    crypto_req = 1'b1; ks_ready = 1'b1; div_in = {8{32'h0000_0002}};
    #1;
    chk("R9 no pull on restart", iter_mode, M_HOLD);
    adv();
    crypto_req = 1'b0; ks_ready = 1'b0;
    #1;
    chk("R9 clear", iter_mode, M_CLR);
    chk("R9 nothing released", out_valid, 1'b0);
    adv();
    #1;
    chk("R9 key reload", push_word, {8{32'hAAAA_5555}});
    adv();
    #1;
    chk("R9 fresh div", push_word, {8{32'h0000_0002}});
    chk("R9 div sel", in_sel, S_DIV);

    // R9: hash request during keystream switches protocol
    do_reset();
    run_stream(1, 8'hFF, {8{32'h1}}, {8{32'h2}});
    hash_req = 1'b1;
    #1;
    chk("R9 hash restart hold", iter_mode, M_HOLD);
    adv();
    hash_req = 1'b0;
    #1;
    chk("R9 hash restart clear", iter_mode, M_CLR);
    adv();
    #1;
    chk("R9 now absorbing", msg_ready, 1'b1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule